// File: doc/BRIEF.md
# Ring-Oscillator Entropy Sampler

This block collects raw entropy from a bank of 128 free-running bit sources. These are meant to be ring oscillators, and they reach the block asynchronously. Each source first passes through a two-flop synchronizer. The sources are organized as 16 groups of eight, and a control word picks which group is active. While sampling is enabled, the block takes one bit from each of the eight selected sources on every clock. After eight clocks it has a 64-bit word, which it pushes into a 64-deep output FIFO of 64-bit words (512 bytes).

Software fills the FIFO by enabling the sampler, then drains it one word at a time through the read port. Sampling stops only while the FIFO is full. As soon as a word is popped, sampling resumes and the FIFO refills. If software reads an empty FIFO, it gets zero with the valid flag low, and a sticky underflow flag is set. The next control write clears that flag. A control write with the reset bit set disables the sampler and empties the FIFO.

Top module: `entropy_sampler`

## Requirements
- R1: A control write loads an 8-bit word with this encoding: bit 0 is soft reset, bit 1 is generator enable, bit 2 is entropy enable, bit 3 is raw-exposure enable, and bits [7:4] are the group number g, which selects sources 8g to 8g+7.
- R2: A control write with bit 0 set clears all three enables and empties the FIFO. `fifoEmpty` is high one cycle later, and no words are produced until a later write enables sampling again.
- R3: Words are produced only while the generator, entropy and raw-exposure enables are all set. With any one of them clear, the FIFO stays empty.
- R4: Each output word takes exactly 8 sample cycles. Bits [8k+7:8k] hold eight consecutive samples of source 8g+k, with the oldest sample in bit 8k.
- R5: After a control write, the word being assembled is discarded. Assembly restarts, and later words come from the group named by that write.
- R6: The FIFO holds 64 words. When it is full, sampling pauses, so no stored word is overwritten. Words are read out in the order they were produced.
- R7: After a pop from a full FIFO, sampling resumes automatically and refills the FIFO.
- R8: When `rdEn` is high while the FIFO is not empty, the next cycle shows the oldest word on `rdData` with `rdValid` high.
- R9: When `rdEn` is high while the FIFO is empty, the next cycle shows `rdData` at zero and `rdValid` low. `underflow` is set and stays set until the next control write.
- R10: Any control write without a coincident empty read clears `underflow`.
- R11: Each source passes through a two-flop synchronizer. A sample taken at clock edge e therefore reflects the input value that was present three edges earlier. The first sample after a control write is taken at the second edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| entIn | input | 128 | Asynchronous entropy source bits |
| ctlWrEn | input | 1 | Control write strobe |
| ctlWrData | input | 8 | Control word (R1 encoding) |
| rdEn | input | 1 | Pop one word from the FIFO |
| rdData | output | 64 | Popped word, zero on an empty read |
| rdValid | output | 1 | rdData holds a popped word |
| fifoEmpty | output | 1 | FIFO holds no words |
| underflow | output | 1 | Sticky flag for a read from an empty FIFO |

## Verification
The assertions check the read-port rules on every cycle: an empty read returns zero with `rdValid` low and sets `underflow`, `rdValid` never appears without a preceding `rdEn`, `underflow` stays set until a control write, a reset write empties the FIFO, and a disabled sampler never fills an empty FIFO. Some behaviours can only be shown by the bench scenarios against a time-varying source pattern: the bit packing and sample age within a word, the group selection, the discarding of a partial word, the pause at full without overwrite, and the refill after a pop.

// File: rtl/es_pkg.sv
package es_pkg;
  localparam int unsigned SRC_COUNT  = 128;
  localparam int unsigned GROUP_SIZE = 8;
  localparam int unsigned SAMPLE_LEN = 8;
  localparam int unsigned FIFO_DEPTH = 64;

  localparam int unsigned GROUP_COUNT = SRC_COUNT / GROUP_SIZE;
  localparam int unsigned GRP_W       = $clog2(GROUP_COUNT);
  localparam int unsigned WORD_W      = GROUP_SIZE * SAMPLE_LEN;
  localparam int unsigned CTL_W       = 4 + GRP_W;

  // control word bit positions
  localparam int unsigned RST_BIT = 0;
  localparam int unsigned GEN_BIT = 1;
  localparam int unsigned ENT_BIT = 2;
  localparam int unsigned RAW_BIT = 3;
  localparam int unsigned GRP_LSB = 4;

  typedef struct packed {
    logic             flush;
    logic             restart;
    logic             sampleEn;
    logic [GRP_W-1:0] grp;
  } strobe_t;
endpackage

// File: rtl/es_ctrl.sv
module es_ctrl
  import es_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             rdEn,
  input  logic             fifoEmpty,
  output strobe_t          strb,
  output logic             underflow
);
  logic             genEn, entEn, rawEn;
  logic [GRP_W-1:0] grpSel;
  logic             softRst;

  assign softRst = ctlWrEn && ctlWrData[RST_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genEn  <= 1'b0;
      entEn  <= 1'b0;
      rawEn  <= 1'b0;
      grpSel <= '0;
    end else if (softRst) begin
      genEn  <= 1'b0;
      entEn  <= 1'b0;
      rawEn  <= 1'b0;
      grpSel <= '0;
    end else if (ctlWrEn) begin
      genEn  <= ctlWrData[GEN_BIT];
      entEn  <= ctlWrData[ENT_BIT];
      rawEn  <= ctlWrData[RAW_BIT];
      grpSel <= ctlWrData[GRP_LSB +: GRP_W];
    end
  end

  // empty read sets the flag; a control write clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   underflow <= 1'b0;
    else if (rdEn && fifoEmpty)  underflow <= 1'b1;
    else if (ctlWrEn)            underflow <= 1'b0;
  end

  always_comb begin
    strb.flush    = softRst;
    strb.restart  = ctlWrEn;
    strb.sampleEn = genEn && entEn && rawEn;
    strb.grp      = grpSel;
  end
endmodule

// File: rtl/es_datapath.sv
module es_datapath
  import es_pkg::*;
#(
  parameter int unsigned NumSrc   = SRC_COUNT,
  parameter int unsigned GrpSize  = GROUP_SIZE,
  parameter int unsigned SmpLen   = SAMPLE_LEN,
  parameter int unsigned Depth    = FIFO_DEPTH
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NumSrc-1:0]         entIn,
  input  strobe_t                   strb,
  input  logic                      rdEn,
  output logic [GrpSize*SmpLen-1:0] rdData,
  output logic                      rdValid,
  output logic                      fifoEmpty
);
  localparam int unsigned WordW  = GrpSize * SmpLen;
  localparam int unsigned AddrW  = $clog2(Depth);
  localparam int unsigned CntW   = $clog2(SmpLen);
  localparam int unsigned IdxW   = $clog2(NumSrc);
  localparam logic [CntW-1:0]  LastBit = CntW'(SmpLen - 1);
  localparam logic [AddrW:0]   FullCnt = (AddrW+1)'(Depth);

  // two-flop synchronizer on every source
  logic [NumSrc-1:0] syncA, syncB;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= entIn;
      syncB <= syncA;
    end
  end

  logic [IdxW-1:0]    grpBase;
  logic [GrpSize-1:0] grpBits;
  assign grpBase = IdxW'(strb.grp) * IdxW'(GrpSize);
  assign grpBits = syncB[grpBase +: GrpSize];

  logic [AddrW:0]   count;
  logic             full, push, pop, sampleStep;
  logic [CntW-1:0]  bitCnt;
  logic [WordW-1:0] nextWord;

  assign full       = (count == FullCnt);
  assign fifoEmpty  = (count == '0);
  assign sampleStep = strb.sampleEn && !full && !strb.restart;
  assign push       = sampleStep && (bitCnt == LastBit);
  assign pop        = rdEn && !fifoEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              bitCnt <= '0;
    else if (strb.restart)  bitCnt <= '0;
    else if (sampleStep)    bitCnt <= (bitCnt == LastBit) ? '0 : bitCnt + 1'b1;
  end

  // one shift lane per source of the group; newest sample enters at the top
  for (genvar k = 0; k < GrpSize; k++) begin : g_lane
    logic [SmpLen-1:0] shReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           shReg <= '0;
      else if (sampleStep) shReg <= {grpBits[k], shReg[SmpLen-1:1]};
    end
    assign nextWord[k*SmpLen +: SmpLen] = {grpBits[k], shReg[SmpLen-1:1]};
  end

  // word FIFO
  logic [WordW-1:0] mem [Depth];
  logic [AddrW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= nextWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= pop;
      rdData  <= pop ? mem[rdPtr] : '0;
    end
  end
endmodule

// File: rtl/entropy_sampler.sv
module entropy_sampler
  import es_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] entIn,
  input  logic                 ctlWrEn,
  input  logic [CTL_W-1:0]     ctlWrData,
  input  logic                 rdEn,
  output logic [WORD_W-1:0]    rdData,
  output logic                 rdValid,
  output logic                 fifoEmpty,
  output logic                 underflow
);
  strobe_t strb;

  es_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctlWrEn   (ctlWrEn),
    .ctlWrData (ctlWrData),
    .rdEn      (rdEn),
    .fifoEmpty (fifoEmpty),
    .strb      (strb),
    .underflow (underflow)
  );

  es_datapath #(
    .NumSrc  (SRC_COUNT),
    .GrpSize (GROUP_SIZE),
    .SmpLen  (SAMPLE_LEN),
    .Depth   (FIFO_DEPTH)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .entIn     (entIn),
    .strb      (strb),
    .rdEn      (rdEn),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .fifoEmpty (fifoEmpty)
  );
endmodule

// File: rtl/es_checker.sv
module es_checker
  import es_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ctlWrEn,
  input logic              softRst,
  input logic              rdEn,
  input logic [WORD_W-1:0] rdData,
  input logic              rdValid,
  input logic              fifoEmpty,
  input logic              underflow,
  input logic              sampleEn
);
  // R9
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && fifoEmpty |=> !rdValid && rdData == '0);

  // R9
  empty_read_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && fifoEmpty |=> underflow);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflow && !ctlWrEn |=> underflow);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn && !(rdEn && fifoEmpty) |=> !underflow);

  // R8
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn) && !$past(fifoEmpty));

  // R2
  reset_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn && softRst |=> fifoEmpty);

  // R3
  gated_stays_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn && fifoEmpty |=> fifoEmpty);
endmodule

bind entropy_sampler es_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .ctlWrEn   (ctlWrEn),
  .softRst   (ctlWrData[0]),
  .rdEn      (rdEn),
  .rdData    (rdData),
  .rdValid   (rdValid),
  .fifoEmpty (fifoEmpty),
  .underflow (underflow),
  .sampleEn  (strb.sampleEn)
);

// File: tb/entropy_sampler_tb_top.sv
`timescale 1ns/1ps
module entropy_sampler_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] entIn = '0;
  logic         ctlWrEn = 1'b0;
  logic [7:0]   ctlWrData = '0;
  logic         rdEn = 1'b0;
  logic [63:0]  rdData;
  logic         rdValid, fifoEmpty, underflow;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  entropy_sampler dut_i (
    .clk(clk), .rstN(rstN), .entIn(entIn), .ctlWrEn(ctlWrEn),
    .ctlWrData(ctlWrData), .rdEn(rdEn), .rdData(rdData),
    .rdValid(rdValid), .fifoEmpty(fifoEmpty), .underflow(underflow)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic patBit(int t, int s);
    return (((t * (s + 3)) + ((t >> 2) * s) + s) % 7) < 3;
  endfunction

  // time-varying source pattern, a function of the edge count
  always @(negedge clk)
    for (int s = 0; s < 128; s++) entIn[s] <= patBit(cyc, s);

  // R11: first sample at edge w+2 sees the value driven after edge w-1
  // R4: byte k = source 8g+k, oldest sample in the lowest bit
  function automatic logic [63:0] expWord(int w, int m, int g);
    logic [63:0] r;
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < 8; j++)
        r[8*k+j] = patBit(w - 1 + 8*m + j, 8*g + k);
    return r;
  endfunction

  function automatic logic [7:0] cfg(int g, bit gen, bit ent, bit raw, bit rst);
    return {g[3:0], raw, ent, gen, rst};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ctlWrite(logic [7:0] d, output int w);
    @(negedge clk);
    w = cyc;
    ctlWrEn = 1'b1;
    ctlWrData = d;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic readWord();
    @(negedge clk);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic testResetState();
    chk(fifoEmpty == 1'b1, "R2 reset empty", 64'(fifoEmpty), 64'd1);
    chk(rdValid == 1'b0, "R8 reset valid", 64'(rdValid), 64'd0);
    chk(underflow == 1'b0, "R9 reset flag", 64'(underflow), 64'd0);
  endtask

  // R4 R6 R1: fill to full, wait, drain 64 words in order
  task automatic testFillOrder();
    int w, wa;
    ctlWrite(cfg(0, 0, 0, 0, 1), w);
    ctlWrite(cfg(3, 1, 1, 1, 0), wa);
    repeat (600) @(negedge clk);
    for (int m = 0; m < 64; m++) begin
      logic [63:0] e;
      e = expWord(wa, m, 3);
      readWord();
      chk(rdValid == 1'b1, "R8 valid on read", 64'(rdValid), 64'd1);
      chk(rdData == e, "R4 R6 word content/order", rdData, e);
    end
  endtask

  // R7 R9 R10: refill after pops, then drain to underflow
  task automatic testRefill();
    int w, n;
    repeat (600) @(negedge clk);
    for (int i = 0; i < 3; i++) readWord();
    repeat (40) @(negedge clk);
    ctlWrite(cfg(3, 1, 1, 0, 0), w);
    n = 0;
    for (int i = 0; i < 70; i++) begin
      readWord();
      if (!rdValid) break;
      n++;
    end
    chk(n == 64, "R7 refilled count", 64'(n), 64'd64);
    chk(rdData == 64'd0, "R9 empty read data", rdData, 64'd0);
    chk(underflow == 1'b1, "R9 flag set", 64'(underflow), 64'd1);
    repeat (5) @(negedge clk);
    chk(underflow == 1'b1, "R9 flag sticky", 64'(underflow), 64'd1);
    ctlWrite(cfg(3, 1, 1, 0, 0), w);
    chk(underflow == 1'b0, "R10 flag cleared", 64'(underflow), 64'd0);
  endtask

  // R3: any one missing enable keeps the FIFO empty
  task automatic testGating();
    int w;
    logic [7:0] cfgs [3];
    cfgs[0] = cfg(5, 0, 1, 1, 0);
    cfgs[1] = cfg(5, 1, 0, 1, 0);
    cfgs[2] = cfg(5, 1, 1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      ctlWrite(cfg(0, 0, 0, 0, 1), w);
      ctlWrite(cfgs[i], w);
      repeat (30) @(negedge clk);
      chk(fifoEmpty == 1'b1, "R3 gated empty", 64'(fifoEmpty), 64'd1);
      readWord();
      chk(rdValid == 1'b0, "R3 gated no word", 64'(rdValid), 64'd0);
    end
  endtask

  // R2: reset write empties and disables
  task automatic testSoftReset();
    int w;
    ctlWrite(cfg(7, 1, 1, 1, 0), w);
    repeat (50) @(negedge clk);
    chk(fifoEmpty == 1'b0, "R2 words before reset", 64'(fifoEmpty), 64'd0);
    ctlWrite(cfg(7, 1, 1, 1, 1), w);
    chk(fifoEmpty == 1'b1, "R2 emptied", 64'(fifoEmpty), 64'd1);
    repeat (50) @(negedge clk);
    chk(fifoEmpty == 1'b1, "R2 stays disabled", 64'(fifoEmpty), 64'd1);
    readWord();
    chk(rdValid == 1'b0, "R2 no word after reset", 64'(rdValid), 64'd0);
  endtask

  // R5: group change mid-word discards the partial word
  task automatic testGroupChange();
    int w, wa, wb;
    logic [63:0] e;
    ctlWrite(cfg(0, 0, 0, 0, 1), w);
    ctlWrite(cfg(3, 1, 1, 1, 0), wa);
    repeat (10) @(negedge clk);
    ctlWrite(cfg(9, 1, 1, 1, 0), wb);
    repeat (30) @(negedge clk);
    e = expWord(wa, 0, 3);
    readWord();
    chk(rdData == e, "R5 old group word", rdData, e);
    e = expWord(wb, 0, 9);
    readWord();
    chk(rdData == e, "R5 new group first word", rdData, e);
    e = expWord(wb, 1, 9);
    readWord();
    chk(rdData == e, "R5 new group second word", rdData, e);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testFillOrder();
    testRefill();
    testGating();
    testSoftReset();
    testGroupChange();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule